// File: doc/BRIEF.md
# Vector High-Half Narrowing Add/Subtract Unit

This block is a packed-vector arithmetic stage. It takes two 128-bit operands made of double-width signed lanes and either adds or subtracts them lane by lane. It can first add a half-LSB rounding constant. From each double-width lane result it keeps only the upper half. The narrowed lanes are packed into a 64-bit vector.

That 64-bit vector is merged into a 128-bit destination. It can go into the low half, with the high half zeroed. It can also go into the high half, with the low half taken unchanged from the previous destination value. A 2-bit size code selects narrow lanes of 8, 16 or 32 bits, and the fourth code is reserved.

The datapath has a fixed latency of one register stage. An input strobe produces a result strobe exactly one cycle later, whatever the operand values are. Operand fetch, register-file writeback and privilege checks are handled by the surrounding pipeline.

Top module: `vec_hinarrow_unit`

## Requirements
- R1: `size_code` selects the narrow lane width: 0 gives 8 bits (8 lanes), 1 gives 16 bits (4 lanes), 2 gives 32 bits (2 lanes). Source lane e sits at bits [(e+1)*2w-1 : e*2w] of each operand, and narrow lane e sits at bits [(e+1)*w-1 : e*w] of the 64-bit result.
- R2: With `sub_sel`=1 each lane computes `opa` lane minus `opb` lane. With `sub_sel`=0 it computes their sum.
- R3: With `rnd_sel`=1 the constant 1<<(w-1) is added to the double-width lane result before narrowing. With `rnd_sel`=0 the result is truncated.
- R4: Each narrow lane equals bits [2w-1:w] of the double-width intermediate. All arithmetic wraps modulo 2^(2w), and any carry out of the lane is discarded.
- R5: With `hi_sel`=0, `dst_new`[63:0] holds the packed result and `dst_new`[127:64] is zero.
- R6: With `hi_sel`=1, `dst_new`[127:64] holds the packed result and `dst_new`[63:0] equals `dst_prev`[63:0].
- R7: `size_code`=3 sets `undef_flag` and makes `dst_new` equal to `dst_prev`, so the destination is left unchanged. Defined codes clear `undef_flag`.
- R8: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, for any data. When `in_valid` is low, `out_valid` falls to 0 on the next cycle and `dst_new` and `undef_flag` hold their values.
- R9: After a synchronous active-low reset, `out_valid`, `undef_flag` and `dst_new` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| opa | input | 128 | First operand, double-width lanes |
| opb | input | 128 | Second operand, double-width lanes |
| dst_prev | input | 128 | Previous destination value |
| size_code | input | 2 | Narrow width select (3 = reserved) |
| sub_sel | input | 1 | 1 = subtract, 0 = add |
| rnd_sel | input | 1 | 1 = add rounding constant |
| hi_sel | input | 1 | 1 = write the high half, 0 = write the low half and zero the high half |
| out_valid | output | 1 | Result strobe |
| dst_new | output | 128 | New destination value |
| undef_flag | output | 1 | Reserved size code seen |

## Verification
Every result appears on the clock edge that follows the edge at which `in_valid` is sampled. This applies to `dst_new`, `undef_flag` and `out_valid`. The bench drives each operation at a falling edge and removes the strobe at the next falling edge. It reads all three outputs at that point, which is half a cycle after the capturing edge.

For the hold behaviour, the bench then lets several idle cycles pass while it changes the inputs. It samples again at falling edges and expects the same outputs with `out_valid` low. The bench computes reference values lane by lane from the requirements. It also checks hand-worked wraparound and rounding cases.

// File: rtl/vhn_pkg.sv
// Package: shared constants and the size-code type for the high-narrow unit.
// Assumes the narrow width doubles with each size code starting at 8 bits.
package vhn_pkg;

    localparam int unsigned NUM_SIZES = 3;
    localparam int unsigned BASE_ESZ  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } vhn_size_e;

    // Narrow lane width for a given size index.
    function automatic int unsigned narrow_width(input int unsigned idx);
        return BASE_ESZ << idx;
    endfunction

endpackage

// File: rtl/vhn_lane.sv
// Module: one lane. Adds or subtracts two double-width values, optionally
// adds a half-LSB rounding constant, and returns the upper half.
// Assumes: all arithmetic wraps modulo 2^(2*ESZ); there is no data-dependent path.
module vhn_lane #(
    parameter int unsigned ESZ = 8
) (
    input  logic [2*ESZ-1:0] a,
    input  logic [2*ESZ-1:0] b,
    input  logic             sub,
    input  logic             rnd,
    output logic [ESZ-1:0]   q
);
    localparam int unsigned TW = 2 * ESZ;

    logic [TW-1:0] b_eff;
    logic [TW-1:0] cin_v;
    logic [TW-1:0] rc_v;
    logic [TW-1:0] total;

    // Two's-complement subtract as invert plus carry-in; rounding constant add.
    always_comb begin
        b_eff = sub ? ~b : b;
        cin_v = {{(TW-1){1'b0}}, sub};
        rc_v  = rnd ? (TW'(1) << (ESZ - 1)) : '0;
        total = a + b_eff + cin_v + rc_v;
        q     = total[TW-1:ESZ];
    end
endmodule

// File: rtl/vhn_pack.sv
// Module: one fixed lane width. Instantiates NW/ESZ lanes across the operands
// and packs their narrowed outputs into an NW-bit vector.
// Assumes: NW is a multiple of ESZ; lane e is at e*2*ESZ in each source.
module vhn_pack #(
    parameter int unsigned NW  = 64,
    parameter int unsigned ESZ = 8
) (
    input  logic [2*NW-1:0] a,
    input  logic [2*NW-1:0] b,
    input  logic            sub,
    input  logic            rnd,
    output logic [NW-1:0]   q
);
    localparam int unsigned LANES = NW / ESZ;
    localparam int unsigned SW    = 2 * ESZ;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        vhn_lane #(.ESZ(ESZ)) u_lane (
            .a   (a[e*SW +: SW]),
            .b   (b[e*SW +: SW]),
            .sub (sub),
            .rnd (rnd),
            .q   (q[e*ESZ +: ESZ])
        );
    end
endmodule

// File: rtl/vhn_merge.sv
// Module: places the narrowed vector into the low half (high half zeroed)
// or into the high half (low half kept from the previous value).
// Assumes: the destination is exactly twice the width of the narrow vector.
module vhn_merge #(
    parameter int unsigned NW = 64
) (
    input  logic [NW-1:0]   narrow,
    input  logic [2*NW-1:0] prev,
    input  logic            hi_sel,
    output logic [2*NW-1:0] merged
);
    // Choose the destination half.
    always_comb begin
        if (hi_sel) merged = {narrow, prev[NW-1:0]};
        else        merged = {{NW{1'b0}}, narrow};
    end
endmodule

// File: rtl/vec_hinarrow_unit.sv
// Module: top of the high-narrow add/subtract unit. Builds one packer per
// legal size, selects one by size code, merges it into the destination and
// registers the outputs. Latency is one cycle and does not depend on the data.
// Assumes: synchronous active-low reset; size code 3 is reserved.
module vec_hinarrow_unit
    import vhn_pkg::*;
#(
    parameter int unsigned NARROW_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2*NARROW_W-1:0]   opa,
    input  logic [2*NARROW_W-1:0]   opb,
    input  logic [2*NARROW_W-1:0]   dst_prev,
    input  logic [1:0]              size_code,
    input  logic                    sub_sel,
    input  logic                    rnd_sel,
    input  logic                    hi_sel,
    output logic                    out_valid,
    output logic [2*NARROW_W-1:0]   dst_new,
    output logic                    undef_flag
);
    localparam int unsigned DW = 2 * NARROW_W;

    logic [NARROW_W-1:0] res_by_size [NUM_SIZES];
    logic [NARROW_W-1:0] narrow_sel;
    logic [DW-1:0]       merged;
    logic [DW-1:0]       next_dst;
    logic                is_rsvd;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        vhn_pack #(
            .NW  (NARROW_W),
            .ESZ (narrow_width(s))
        ) u_pack (
            .a   (opa),
            .b   (opb),
            .sub (sub_sel),
            .rnd (rnd_sel),
            .q   (res_by_size[s])
        );
    end

    // Select the packed result for the requested lane width.
    always_comb begin
        case (vhn_size_e'(size_code))
            SZ_BYTE: narrow_sel = res_by_size[0];
            SZ_HALF: narrow_sel = res_by_size[1];
            SZ_WORD: narrow_sel = res_by_size[2];
            default: narrow_sel = '0;
        endcase
    end

    vhn_merge #(.NW(NARROW_W)) u_merge (
        .narrow (narrow_sel),
        .prev   (dst_prev),
        .hi_sel (hi_sel),
        .merged (merged)
    );

    // A reserved size code leaves the destination unchanged.
    always_comb begin
        is_rsvd  = (vhn_size_e'(size_code) == SZ_RSVD);
        next_dst = is_rsvd ? dst_prev : merged;
    end

    // Output register stage with a one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            dst_new    <= '0;
            undef_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_new    <= next_dst;
                undef_flag <= is_rsvd;
            end
        end
    end

    // R8: the strobe follows the input by exactly one cycle
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: idle cycles hold the outputs and drop the strobe
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dst_new) && $stable(undef_flag)));

    // R7: a reserved code flags and keeps the destination
    a_r7_rsvd_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'd3) |=> (undef_flag && dst_new == $past(dst_prev)));

    // R5: a low-half write clears the upper half
    a_r5_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code != 2'd3 && !hi_sel) |=> (dst_new[DW-1:NARROW_W] == '0 && !undef_flag));

    // R6: a high-half write keeps the lower half
    a_r6_high_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code != 2'd3 && hi_sel) |=> (dst_new[NARROW_W-1:0] == $past(dst_prev[NARROW_W-1:0])));

endmodule

// File: tb/vec_hinarrow_unit_tb.sv
module vec_hinarrow_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0, opb = '0, dst_prev = '0;
    logic [1:0]   size_code = '0;
    logic         sub_sel = 1'b0, rnd_sel = 1'b0, hi_sel = 1'b0;
    logic         out_valid;
    logic [127:0] dst_new;
    logic         undef_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    vec_hinarrow_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opa(opa), .opb(opb), .dst_prev(dst_prev),
        .size_code(size_code), .sub_sel(sub_sel), .rnd_sel(rnd_sel), .hi_sel(hi_sel),
        .out_valid(out_valid), .dst_new(dst_new), .undef_flag(undef_flag)
    );

    function automatic logic [127:0] ref_dst(
        input logic [127:0] a, input logic [127:0] b, input logic [127:0] prev,
        input logic [1:0] sz, input logic sub, input logic rnd, input logic hi);
        logic [63:0] narrow = '0;
        if (sz == 2'd3) return prev;
        begin
            int esz = 8 << sz;
            int lanes = 64 / esz;
            logic [63:0] mask = (esz == 32) ? '1 : ((64'd1 << (2*esz)) - 64'd1);
            logic [63:0] emask = (64'd1 << esz) - 64'd1;
            for (int e = 0; e < lanes; e++) begin
                logic [127:0] ta = a >> (e*2*esz);
                logic [127:0] tb = b >> (e*2*esz);
                logic [63:0] la = ta[63:0] & mask;
                logic [63:0] lb = tb[63:0] & mask;
                logic [63:0] s = sub ? (la - lb) : (la + lb);
                if (rnd) s = s + (64'd1 << (esz-1));
                s = s & mask;
                narrow = narrow | (((s >> esz) & emask) << (e*esz));
            end
        end
        return hi ? {narrow, prev[63:0]} : {64'd0, narrow};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation, then sample half a cycle after the capturing edge.
    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [127:0] p,
                          input logic [1:0] sz, input logic sub, input logic rnd, input logic hi);
        @(negedge clk);
        opa = a; opb = b; dst_prev = p; size_code = sz;
        sub_sel = sub; rnd_sel = rnd; hi_sel = hi; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 out_valid", {127'd0, out_valid}, 128'd0);
        check("R9 dst_new", dst_new, 128'd0);
        check("R9 undef_flag", {127'd0, undef_flag}, 128'd0);
    endtask

    task automatic t_sweep();
        logic [127:0] pa [2] = '{128'h8001_7FFF_0123_FEDC_BA98_7654_FFFF_0000,
                                 128'h0F0F_F0F0_8000_0001_7FFF_FFFF_1234_5678};
        logic [127:0] pb [2] = '{128'h7FFF_8001_FFFF_0001_0080_FF80_0001_FFFF,
                                 128'hFFFF_0000_7FFF_8000_0000_0001_89AB_CDEF};
        logic [127:0] pp = 128'hDEAD_BEEF_CAFE_F00D_0123_4567_89AB_CDEF;
        for (int sz = 0; sz < 3; sz++)
            for (int sb = 0; sb < 2; sb++)
                for (int rd = 0; rd < 2; rd++)
                    for (int hi = 0; hi < 2; hi++)
                        for (int k = 0; k < 2; k++) begin
                            run_op(pa[k], pb[k], pp, 2'(sz), sb[0], rd[0], hi[0]);
                            check(hi ? "R1 R2 R3 R4 R6 sweep" : "R1 R2 R3 R4 R5 sweep",
                                  dst_new, ref_dst(pa[k], pb[k], pp, 2'(sz), sb[0], rd[0], hi[0]));
                            check("R8 strobe", {127'd0, out_valid}, 128'd1);
                            check("R7 clear flag", {127'd0, undef_flag}, 128'd0);
                        end
    endtask

    task automatic t_wrap();
        // 8 lanes of 0x7FFF + 0x7FFF = 0xFFFE, upper byte 0xFF
        run_op({8{16'h7FFF}}, {8{16'h7FFF}}, '1, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R4 add wrap byte", dst_new, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
        // 2 lanes of min - 1 = max positive, upper word 0x7FFFFFFF, into the high half
        run_op({2{64'h8000_0000_0000_0000}}, {2{64'h1}}, 128'h0_1234_5678_9ABC_DEF0,
               2'd2, 1'b1, 1'b0, 1'b1);
        check("R4 R6 sub wrap word", dst_new, {64'h7FFF_FFFF_7FFF_FFFF, 64'h1234_5678_9ABC_DEF0});
        // 0xFFFF + 0x0001 + 0x80 wraps to 0x0080, upper byte 0
        run_op({8{16'hFFFF}}, {8{16'h0001}}, '0, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R3 R4 carry discarded", dst_new, 128'd0);
    endtask

    task automatic t_round();
        // 0x0080 in 16-bit lanes: truncation gives 0x00, rounding gives 0x01
        run_op({8{16'h0080}}, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
        check("R3 truncate", dst_new, 128'd0);
        run_op({8{16'h0080}}, '0, '0, 2'd0, 1'b0, 1'b1, 1'b0);
        check("R3 round up", dst_new, {64'd0, 64'h0101_0101_0101_0101});
        // 32-bit lanes: 0x0000_8000 - 0 rounded gives 0x0001
        run_op({4{32'h0000_8000}}, '0, '0, 2'd1, 1'b1, 1'b1, 1'b0);
        check("R1 R3 half round", dst_new, {64'd0, 64'h0001_0001_0001_0001});
    endtask

    task automatic t_undef();
        logic [127:0] p = 128'hA5A5_5A5A_0F0F_F0F0_1111_2222_3333_4444;
        run_op('1, 128'h5, p, 2'd3, 1'b1, 1'b1, 1'b0);
        check("R7 dst kept", dst_new, p);
        check("R7 flag set", {127'd0, undef_flag}, 128'd1);
        run_op('1, 128'h5, p, 2'd3, 1'b0, 1'b0, 1'b1);
        check("R7 dst kept hi", dst_new, p);
    endtask

    task automatic t_idle();
        logic [127:0] held;
        run_op({8{16'h1234}}, {8{16'h0034}}, '0, 2'd0, 1'b1, 1'b0, 1'b0);
        held = dst_new;
        check("R8 result", held, {64'd0, 64'h1212_1212_1212_1212});
        for (int i = 0; i < 4; i++) begin
            opa = ~opa; opb = opb + 128'd77; size_code = 2'(i); hi_sel = ~hi_sel;
            @(negedge clk);
            check("R8 idle strobe low", {127'd0, out_valid}, 128'd0);
            check("R8 idle hold", dst_new, held);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_wrap();
        t_round();
        t_undef();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule